// File: doc/BRIEF.md
# Crate Control Bus Cycle Sequencer

This block turns one host command into one framed cycle on a parallel crate control bus. The host presents the command fields and a one-clock start pulse: a motherboard address, a card address, a function address, a write data byte and a read/write select. The block then walks the bus through six steps of equal length. It places the motherboard address, then the card address together with the transfer direction, then the function address, then the write data. After that it raises the strobe and finally drops it. The length of each step is a parameter counted in system clocks. Every bus line comes from a register, so a line changes only at a step boundary.

A read cycle uses the same framing. The direction line shows read and the write data lane is left alone. The byte on the read lane is captured on the clock edge at which the strobe is released. A busy flag covers the whole cycle. A one-clock done pulse marks its end. A start request that arrives while busy is dropped. Bus lanes keep their last values between cycles.

Top module: `cbus_cycle_seq`

## Requirements
- R1: After reset the strobe is low, direction is 0 (read), the motherboard, card, function and write data lanes are zero, the captured read byte is zero, and busy and done are low.
- R2: A start pulse sampled while idle is accepted on that edge (edge A). From edge A on, busy is high and the motherboard lane carries the requested address.
- R3: With N = STEP_CLKS, the following lanes change at these edges after edge A. The card lane and direction change at A+N, with direction 1 for write and 0 for read, and the strobe stays low. The function lane changes at A+2N. The write data lane changes at A+3N. The strobe rises at A+4N and falls at A+5N.
- R4: Card address and direction do not change from A+N to the end of the cycle, and they are stable across both strobe edges.
- R5: At edge A+6N busy falls and done goes high for exactly one clock.
- R6: A start pulse or any change of the command inputs while busy has no effect on the running cycle or its lanes.
- R7: In a read cycle the write data lane keeps its earlier value. The captured read byte takes the read lane value present at edge A+5N and holds it afterwards.
- R8: A write cycle leaves the captured read byte unchanged.
- R9: After a cycle ends, all bus lanes and the direction line keep their values until the next accepted cycle changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock request to run a cycle |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| mba_i | input | MBA_W | Requested motherboard address |
| card_i | input | CARD_W | Requested card address |
| func_i | input | FUNC_W | Requested function address |
| wdata_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock pulse at cycle end |
| rdata_o | output | DATA_W | Byte captured on the last read cycle |
| bus_mba_o | output | MBA_W | Motherboard address lane |
| bus_card_o | output | CARD_W | Card address lane |
| bus_strobe_o | output | 1 | Bus strobe, active high |
| bus_dir_o | output | 1 | Bus direction, 1 = write, 0 = read |
| bus_func_o | output | FUNC_W | Function address lane |
| bus_wdata_o | output | DATA_W | Write data lane |
| bus_rdata_i | input | DATA_W | Read data lane from the bus |

## Verification
Each result has a fixed due time, counted in clocks after the accepting edge A. The motherboard lane and busy are due at A. The later lanes are due at multiples of STEP_CLKS, and done and the fall of busy at A+6N. The bench counts falling edges from A and compares every output at every step against a value computed from those offsets, so an early or late update is seen the clock it happens. To pin down read capture, the bench changes the read lane one clock before A+5N and again right after A+5N. Only the value present at that edge is acceptable.

// File: rtl/cbus_seq_pkg.sv
package cbus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MBA     = 3'd1,
        ST_CARD    = 3'd2,
        ST_FUNC    = 3'd3,
        ST_DATA    = 3'd4,
        ST_STB_ON  = 3'd5,
        ST_STB_OFF = 3'd6
    } step_e;

endpackage

// File: rtl/cbus_step_timer.sv
module cbus_step_timer #(
    parameter int unsigned STEP_CLKS = 500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = '0;
        if (run_i && !last_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/cbus_step_fsm.sv
module cbus_step_fsm
    import cbus_seq_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  start_i,
    input  logic  last_i,
    output step_e step_o,
    output step_e step_nxt_o,
    output logic  done_o
);
    typedef struct packed {
        step_e step;
        logic  done;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.step)
            ST_IDLE:    if (start_i) st_d.step = ST_MBA;
            ST_MBA:     if (last_i)  st_d.step = ST_CARD;
            ST_CARD:    if (last_i)  st_d.step = ST_FUNC;
            ST_FUNC:    if (last_i)  st_d.step = ST_DATA;
            ST_DATA:    if (last_i)  st_d.step = ST_STB_ON;
            ST_STB_ON:  if (last_i)  st_d.step = ST_STB_OFF;
            ST_STB_OFF: if (last_i) begin
                st_d.step = ST_IDLE;
                st_d.done = 1'b1;
            end
            default:    st_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{step: ST_IDLE, done: 1'b0};
        else         st_q <= st_d;
    end

    assign step_o     = st_q.step;
    assign step_nxt_o = st_d.step;
    assign done_o     = st_q.done;

    AST_DONE_FROM_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (st_q.step == ST_IDLE) && ($past(st_q.step) == ST_STB_OFF)); // R5

endmodule

// File: rtl/cbus_cycle_seq.sv
module cbus_cycle_seq
    import cbus_seq_pkg::*;
#(
    parameter int unsigned STEP_CLKS = 500,
    parameter int unsigned MBA_W     = 8,
    parameter int unsigned CARD_W    = 6,
    parameter int unsigned FUNC_W    = 8,
    parameter int unsigned DATA_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [MBA_W-1:0]  mba_i,
    input  logic [CARD_W-1:0] card_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [MBA_W-1:0]  bus_mba_o,
    output logic [CARD_W-1:0] bus_card_o,
    output logic              bus_strobe_o,
    output logic              bus_dir_o,
    output logic [FUNC_W-1:0] bus_func_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    typedef struct packed {
        logic              rd;
        logic [CARD_W-1:0] card;
        logic [FUNC_W-1:0] func;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    typedef struct packed {
        cmd_t              cmd;
        logic [MBA_W-1:0]  mba;
        logic [CARD_W-1:0] card;
        logic              strobe;
        logic              dir;
        logic [FUNC_W-1:0] func;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    step_e step_q, step_nxt;
    logic  last_w;

    assign busy_o = (step_q != ST_IDLE);

    cbus_step_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (busy_o),
        .last_o (last_w)
    );

    cbus_step_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .last_i     (last_w),
        .step_o     (step_q),
        .step_nxt_o (step_nxt),
        .done_o     (done_o)
    );

    always_comb begin
        r_d = r_q;
        if (step_nxt != step_q) begin
            unique case (step_nxt)
                ST_MBA: begin
                    r_d.mba       = mba_i;
                    r_d.cmd.rd    = rd_i;
                    r_d.cmd.card  = card_i;
                    r_d.cmd.func  = func_i;
                    r_d.cmd.wdata = wdata_i;
                end
                ST_CARD: begin
                    r_d.card   = r_q.cmd.card;
                    r_d.dir    = !r_q.cmd.rd;
                    r_d.strobe = 1'b0;
                end
                ST_FUNC:   r_d.func = r_q.cmd.func;
                ST_DATA:   if (!r_q.cmd.rd) r_d.wdata = r_q.cmd.wdata;
                ST_STB_ON: r_d.strobe = 1'b1;
                ST_STB_OFF: begin
                    r_d.strobe = 1'b0;
                    if (r_q.cmd.rd) r_d.rdata = bus_rdata_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign bus_mba_o    = r_q.mba;
    assign bus_card_o   = r_q.card;
    assign bus_strobe_o = r_q.strobe;
    assign bus_dir_o    = r_q.dir;
    assign bus_func_o   = r_q.func;
    assign bus_wdata_o  = r_q.wdata;
    assign rdata_o      = r_q.rdata;

    AST_CARD_HELD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_strobe_o) |-> $stable(bus_card_o) && $stable(bus_dir_o)); // R4
    AST_CARD_HELD_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(bus_strobe_o) |-> $stable(bus_card_o) && $stable(bus_dir_o)); // R4
    AST_STROBE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_strobe_o |-> busy_o); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && $past(busy_o)); // R5
    AST_CMD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) |-> $stable(r_q.cmd)); // R6
    AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && $past(busy_o) && !r_q.cmd.rd |-> $stable(rdata_o)); // R8

endmodule

// File: tb/cbus_cycle_seq_tb_top.sv
module cbus_cycle_seq_tb_top;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] mba = '0;
    logic [5:0] card = '0;
    logic [7:0] func = '0;
    logic [7:0] wdata = '0;
    logic [7:0] bus_rd = '0;
    logic       busy, done, strobe, dir;
    logic [7:0] rdata, o_mba, o_func, o_wdata;
    logic [5:0] o_card;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [7:0] sh_mba = '0, sh_func = '0, sh_wdata = '0, sh_rdata = '0;
    logic [5:0] sh_card = '0;
    logic       sh_dir = 1'b0;

    always #2.5 clk = ~clk;

    cbus_cycle_seq #(.STEP_CLKS(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
        .mba_i(mba), .card_i(card), .func_i(func), .wdata_i(wdata),
        .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .bus_mba_o(o_mba), .bus_card_o(o_card), .bus_strobe_o(strobe),
        .bus_dir_o(dir), .bus_func_o(o_func), .bus_wdata_o(o_wdata),
        .bus_rdata_i(bus_rd)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1", "strobe", 32'(strobe), 0);
        chk("R1", "dir", 32'(dir), 0);
        chk("R1", "mba", 32'(o_mba), 0);
        chk("R1", "card", 32'(o_card), 0);
        chk("R1", "func", 32'(o_func), 0);
        chk("R1", "wdata", 32'(o_wdata), 0);
        chk("R1", "rdata", 32'(rdata), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
    endtask

    task automatic run_cycle(input bit r, input logic [7:0] m, input logic [5:0] c,
                             input logic [7:0] f, input logic [7:0] w,
                             input logic [7:0] rv, input bit poke);
        string t6;
        t6 = poke ? "R6" : "";
        @(negedge clk);
        start = 1'b1; rd = r; mba = m; card = c; func = f; wdata = w;
        bus_rd = rv ^ 8'h3C;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= 6 * N; t++) begin
            chk({"R2 ", t6}, "mba", 32'(o_mba), 32'(m));
            chk({"R4 ", t6}, "card", 32'(o_card), 32'((t >= N) ? c : sh_card));
            chk({"R4 ", t6}, "dir", 32'(dir), 32'((t >= N) ? !r : sh_dir));
            chk({"R3 ", t6}, "func", 32'(o_func), 32'((t >= 2 * N) ? f : sh_func));
            chk({r ? "R7 " : "R3 ", t6}, "wdata", 32'(o_wdata),
                32'((t >= 3 * N && !r) ? w : sh_wdata));
            chk({"R3 ", t6}, "strobe", 32'(strobe), 32'(t >= 4 * N && t < 5 * N));
            chk({"R5 ", t6}, "busy", 32'(busy), 32'(t < 6 * N));
            chk({"R5 ", t6}, "done", 32'(done), 32'(t == 6 * N));
            chk({r ? "R7 " : "R8 ", t6}, "rdata", 32'(rdata),
                32'((r && t >= 5 * N) ? rv : sh_rdata));
            if (poke && t == 2) begin
                start = 1'b1; rd = !r; mba = ~m; card = ~c; func = ~f; wdata = ~w;
            end
            if (poke && t == 3) start = 1'b0;
            if (t == 5 * N - 1) bus_rd = rv;
            if (t == 5 * N)     bus_rd = ~rv;
            @(negedge clk);
        end
        sh_mba = m; sh_card = c; sh_dir = !r; sh_func = f;
        if (!r) sh_wdata = w;
        if (r)  sh_rdata = rv;
        bus_rd = 8'hE7;
        repeat (5) @(negedge clk);
        chk("R9", "mba hold", 32'(o_mba), 32'(sh_mba));
        chk("R9", "card hold", 32'(o_card), 32'(sh_card));
        chk("R9", "dir hold", 32'(dir), 32'(sh_dir));
        chk("R9", "func hold", 32'(o_func), 32'(sh_func));
        chk("R9", "wdata hold", 32'(o_wdata), 32'(sh_wdata));
        chk("R9", "strobe idle", 32'(strobe), 0);
        chk("R9", "busy idle", 32'(busy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_cycle(1'b0, 8'hA5, 6'h2B, 8'h17, 8'hC3, 8'h00, 1'b0);
        run_cycle(1'b1, 8'h5A, 6'h14, 8'hE8, 8'h99, 8'h6D, 1'b0);
        run_cycle(1'b0, 8'hFF, 6'h3F, 8'hFF, 8'h01, 8'h11, 1'b1);
        run_cycle(1'b1, 8'h00, 6'h00, 8'h00, 8'h77, 8'hB2, 1'b1);
        run_cycle(1'b0, 8'h3C, 6'h01, 8'h80, 8'h4E, 8'h22, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule